// File: doc/BRIEF.md
# UART Interrupt Source Identifier

This block sits beside one UART channel and turns that channel's conditions into one active-low interrupt request and a 6-bit identification code. The code names the most urgent source that is pending and enabled. Three sources are levels that the block only observes: the receive error summary, the receive timeout and receive data ready. Five sources are latched by the block: transmit space, modem input change, general I/O input change, flow-control character detection and handshake release. Each latched source has its own clear rule.

Software reads the identification code to learn which source to service. A read strobe for the identification register clears some latched sources. Other sources are cleared by a strobe for their own status register, or by a later event on the line. Enable bits hide a source from the request line and from the code, but they do not stop a latched source from being recorded.

Top module: `uart_irq_ident`

## Requirements
- R1: While `rst` is high and after it falls with no source active, `irq_n_o` is 1 and `iir_id_o` is 6'b000001. All latched sources reset to not pending.
- R2: The code for the highest enabled pending source is shown, in this order from highest to lowest:
  - receive error 6'b000110
  - receive timeout 6'b001100
  - receive data 6'b000100
  - transmit space 6'b000010
  - modem change 6'b000000
  - general I/O change 6'b110000
  - flow character 6'b010000
  - handshake release 6'b100000
- R3: Receive timeout and receive data share one priority level. When both are pending, the timeout code 6'b001100 is shown.
- R4: Enable bits `en_i` are assigned as follows:
  - [0] receive error
  - [1] receive timeout and receive data
  - [2] transmit
  - [3] modem
  - [4] general I/O
  - [5] flow character
  - [6] handshake

  A disabled source is neither reported nor drives the request. A latched source that arrived while disabled is shown in the same cycle its bit is set.
- R5: `irq_n_o` is 0 exactly when an enabled source is pending. It returns to 1 in the same cycle that the last one goes away, and `iir_id_o` is then 6'b000001.
- R6: The receive error, receive timeout and receive data sources follow `lsr_err_i`, `rx_timeout_i` and `rx_ready_i` directly, with no latching.
- R7: A one-cycle `tx_space_i` pulse makes transmit pending from the next cycle. Either of two events clears it: an identification read while transmit is the shown source, or a `tx_wr_i` strobe. If a set and a clear fall in the same cycle, the set wins.
- R8: Modem change is cleared only by `msr_rd_i`, and general I/O change is cleared only by `gpio_rd_i`. An identification read clears neither.
- R9: A flow-control stop character (`xoff_det_i`) stays pending through identification reads until a resume character (`xon_det_i`) is seen.
- R10: A special character (`spec_det_i`) stays pending until an identification read that shows code 6'b010000.
- R11: A handshake interrupt is raised only when `cts_i` or `rts_i` goes from 0 to 1. A 1-to-0 change has no effect. The interrupt is cleared by an identification read that shows code 6'b100000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 7 | Per-source enable bits |
| iir_rd_i | input | 1 | Identification register read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| gpio_rd_i | input | 1 | General I/O status read strobe |
| tx_wr_i | input | 1 | Transmit data write strobe |
| lsr_err_i | input | 1 | Receive FIFO error summary level |
| rx_timeout_i | input | 1 | Receive timeout level |
| rx_ready_i | input | 1 | Receive data ready / above trigger level |
| tx_space_i | input | 1 | Transmit space event pulse |
| modem_chg_i | input | 1 | Modem input change pulse |
| gpio_chg_i | input | 1 | General I/O input change pulse |
| xoff_det_i | input | 1 | Stop character detected pulse |
| xon_det_i | input | 1 | Resume character detected pulse |
| spec_det_i | input | 1 | Special character detected pulse |
| cts_i | input | 1 | Clear-to-send pin level, 0 = active |
| rts_i | input | 1 | Request-to-send pin level, 0 = active |
| irq_n_o | output | 1 | Interrupt request, active low |
| iir_id_o | output | 6 | Identification code |

## Verification
The properties assume the following about the inputs:
- Event inputs are one-cycle pulses that arrive synchronous to `clk`.
- `cts_i` and `rts_i` do not change across the cycle in which reset is released, because handshake edges are judged against a previous sample.
- An interrupt asserted after a stop character or a handshake rise may vanish only when its enable bit is cleared.

The directed tasks drive every input on the falling edge. They hold each pulse for exactly one cycle and keep the pins idle at reset release. They change enables only inside the masking scenario, where the properties allow it.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NUM_SRC   = 8;
    localparam int NUM_EN    = 7;
    localparam int NUM_LATCH = 6;
    localparam int ID_W      = 6;
    localparam int SRC_W     = $clog2(NUM_SRC);

    // Source slots, index equals priority rank (0 = most urgent)
    typedef enum logic [SRC_W-1:0] {
        SRC_LINE  = 3'd0,
        SRC_RXTO  = 3'd1,
        SRC_RXDAT = 3'd2,
        SRC_TX    = 3'd3,
        SRC_MODEM = 3'd4,
        SRC_GPIO  = 3'd5,
        SRC_FLOW  = 3'd6,
        SRC_HSHK  = 3'd7
    } src_e;

    typedef logic [ID_W-1:0] id_t;

    localparam id_t ID_NONE  = 6'b000001;
    localparam id_t ID_LINE  = 6'b000110;
    localparam id_t ID_RXTO  = 6'b001100;
    localparam id_t ID_RXDAT = 6'b000100;
    localparam id_t ID_TX    = 6'b000010;
    localparam id_t ID_MODEM = 6'b000000;
    localparam id_t ID_GPIO  = 6'b110000;
    localparam id_t ID_FLOW  = 6'b010000;
    localparam id_t ID_HSHK  = 6'b100000;

    // Enable bit positions
    localparam int EN_LINE  = 0;
    localparam int EN_RX    = 1;
    localparam int EN_TX    = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_GPIO  = 4;
    localparam int EN_FLOW  = 5;
    localparam int EN_HSHK  = 6;

    // Latch slots
    localparam int L_TX    = 0;
    localparam int L_MODEM = 1;
    localparam int L_GPIO  = 2;
    localparam int L_XOFF  = 3;
    localparam int L_SPEC  = 4;
    localparam int L_HSHK  = 5;

    typedef struct packed {
        logic set;
        logic clr;
    } latch_ctl_t;

    function automatic id_t id_of(input src_e s);
        case (s)
            SRC_LINE:  return ID_LINE;
            SRC_RXTO:  return ID_RXTO;
            SRC_RXDAT: return ID_RXDAT;
            SRC_TX:    return ID_TX;
            SRC_MODEM: return ID_MODEM;
            SRC_GPIO:  return ID_GPIO;
            SRC_FLOW:  return ID_FLOW;
            default:   return ID_HSHK;
        endcase
    endfunction

    function automatic int en_bit(input int slot);
        case (slot)
            0:       return EN_LINE;
            1, 2:    return EN_RX;
            3:       return EN_TX;
            4:       return EN_MODEM;
            5:       return EN_GPIO;
            6:       return EN_FLOW;
            default: return EN_HSHK;
        endcase
    endfunction

endpackage

// File: rtl/uirq_event_latch.sv
module uirq_event_latch
    import uirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  latch_ctl_t ctl_i,
    output logic       pend_o
);

    // A set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst)
            pend_o <= 1'b0;
        else if (ctl_i.set)
            pend_o <= 1'b1;
        else if (ctl_i.clr)
            pend_o <= 1'b0;
    end

endmodule

// File: rtl/uirq_rise_detect.sv
module uirq_rise_detect #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] prev_q;

    // Previous sample starts at the inactive (high) level so a pin that is
    // already high when reset ends is not taken as a release.
    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= '1;
        else
            prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/uirq_prio_pick.sv
module uirq_prio_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  act_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    // Lowest set index wins: scan from the top so the last hit is kept
    always_comb begin
        any_o = |act_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act_i[i])
                idx_o = IW'(i);
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EN-1:0] en_i,
    input  logic              iir_rd_i,
    input  logic              msr_rd_i,
    input  logic              gpio_rd_i,
    input  logic              tx_wr_i,
    input  logic              lsr_err_i,
    input  logic              rx_timeout_i,
    input  logic              rx_ready_i,
    input  logic              tx_space_i,
    input  logic              modem_chg_i,
    input  logic              gpio_chg_i,
    input  logic              xoff_det_i,
    input  logic              xon_det_i,
    input  logic              spec_det_i,
    input  logic              cts_i,
    input  logic              rts_i,
    output logic              irq_n_o,
    output logic [ID_W-1:0]   iir_id_o
);

    logic [NUM_LATCH-1:0] pend;
    latch_ctl_t           ctl [NUM_LATCH];
    logic [1:0]           hs_rise;
    logic [NUM_SRC-1:0]   raw;
    logic [NUM_SRC-1:0]   act;
    logic                 any_act;
    logic [SRC_W-1:0]     sel_idx;
    src_e                 sel;
    logic                 rd_tx, rd_flow, rd_hshk;

    uirq_rise_detect #(.W(2)) u_hs_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  ({rts_i, cts_i}),
        .rise_o (hs_rise)
    );

    // Raw pending view, one slot per priority rank
    always_comb begin
        raw            = '0;
        raw[SRC_LINE]  = lsr_err_i;
        raw[SRC_RXTO]  = rx_timeout_i;
        raw[SRC_RXDAT] = rx_ready_i;
        raw[SRC_TX]    = pend[L_TX];
        raw[SRC_MODEM] = pend[L_MODEM];
        raw[SRC_GPIO]  = pend[L_GPIO];
        raw[SRC_FLOW]  = pend[L_XOFF] | pend[L_SPEC];
        raw[SRC_HSHK]  = pend[L_HSHK];
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
        assign act[g] = raw[g] & en_i[en_bit(g)];
    end

    uirq_prio_pick #(.N(NUM_SRC)) u_pick (
        .act_i (act),
        .any_o (any_act),
        .idx_o (sel_idx)
    );

    assign sel = src_e'(sel_idx);

    // Identification reads clear only the source being shown
    assign rd_tx   = iir_rd_i && any_act && (sel == SRC_TX);
    assign rd_flow = iir_rd_i && any_act && (sel == SRC_FLOW);
    assign rd_hshk = iir_rd_i && any_act && (sel == SRC_HSHK);

    always_comb begin
        ctl[L_TX]    = '{set: tx_space_i,  clr: rd_tx | tx_wr_i};
        ctl[L_MODEM] = '{set: modem_chg_i, clr: msr_rd_i};
        ctl[L_GPIO]  = '{set: gpio_chg_i,  clr: gpio_rd_i};
        ctl[L_XOFF]  = '{set: xoff_det_i,  clr: xon_det_i};
        ctl[L_SPEC]  = '{set: spec_det_i,  clr: rd_flow};
        ctl[L_HSHK]  = '{set: |hs_rise,    clr: rd_hshk};
    end

    for (genvar l = 0; l < NUM_LATCH; l++) begin : g_latch
        uirq_event_latch u_latch (
            .clk    (clk),
            .rst    (rst),
            .ctl_i  (ctl[l]),
            .pend_o (pend[l])
        );
    end

    assign irq_n_o  = ~any_act;
    assign iir_id_o = any_act ? id_of(sel) : ID_NONE;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
    import uirq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NUM_EN-1:0] en_i,
    input logic              iir_rd_i,
    input logic              msr_rd_i,
    input logic              gpio_rd_i,
    input logic              tx_wr_i,
    input logic              lsr_err_i,
    input logic              rx_timeout_i,
    input logic              rx_ready_i,
    input logic              tx_space_i,
    input logic              modem_chg_i,
    input logic              gpio_chg_i,
    input logic              xoff_det_i,
    input logic              xon_det_i,
    input logic              spec_det_i,
    input logic              cts_i,
    input logic              rts_i,
    input logic              irq_n_o,
    input logic [ID_W-1:0]   iir_id_o
);

    p_irq_id_agree_r5: assert property (@(posedge clk) disable iff (rst)
        irq_n_o == (iir_id_o == ID_NONE));

    p_line_first_r2: assert property (@(posedge clk) disable iff (rst)
        (lsr_err_i && en_i[EN_LINE]) |-> (iir_id_o == ID_LINE));

    p_timeout_over_data_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_timeout_i && rx_ready_i && en_i[EN_RX] && !(lsr_err_i && en_i[EN_LINE]))
        |-> (iir_id_o == ID_RXTO));

    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (en_i == '0) |-> irq_n_o);

    p_tx_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (iir_rd_i && iir_id_o == ID_TX && !tx_space_i) |=> (iir_id_o != ID_TX));

    p_xoff_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (xoff_det_i && en_i[EN_FLOW]) |=> (!irq_n_o || !en_i[EN_FLOW]));

    p_hshk_rise_r11: assert property (@(posedge clk) disable iff (rst)
        ($rose(cts_i) && en_i[EN_HSHK]) |=> (!irq_n_o || !en_i[EN_HSHK]));

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (irq_n_o || lsr_err_i || rx_timeout_i || rx_ready_i || !rst));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] en_i = 7'h7F;
    logic iir_rd_i = 0, msr_rd_i = 0, gpio_rd_i = 0, tx_wr_i = 0;
    logic lsr_err_i = 0, rx_timeout_i = 0, rx_ready_i = 0, tx_space_i = 0;
    logic modem_chg_i = 0, gpio_chg_i = 0, xoff_det_i = 0, xon_det_i = 0;
    logic spec_det_i = 0, cts_i = 0, rts_i = 0;
    logic       irq_n_o;
    logic [5:0] iir_id_o;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [5:0] C_NONE  = 6'b000001;
    localparam logic [5:0] C_LINE  = 6'b000110;
    localparam logic [5:0] C_RXTO  = 6'b001100;
    localparam logic [5:0] C_RXDAT = 6'b000100;
    localparam logic [5:0] C_TX    = 6'b000010;
    localparam logic [5:0] C_MODEM = 6'b000000;
    localparam logic [5:0] C_GPIO  = 6'b110000;
    localparam logic [5:0] C_FLOW  = 6'b010000;
    localparam logic [5:0] C_HSHK  = 6'b100000;

    always #5 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [5:0] exp_id);
        logic exp_n;
        exp_n = (exp_id == C_NONE);
        n_run++;
        if (iir_id_o !== exp_id || irq_n_o !== exp_n) begin
            n_fail++;
            $display("FAIL %s: id=%b irq_n=%b expected id=%b irq_n=%b",
                     req, iir_id_o, irq_n_o, exp_id, exp_n);
        end
    endtask

    task automatic ident_read();
        iir_rd_i = 1; tick(); iir_rd_i = 0;
    endtask

    task automatic t_reset();
        rst = 1; tick(); tick();
        check("R1 during reset", C_NONE);
        rst = 0; tick();
        check("R1 after reset", C_NONE);
    endtask

    task automatic t_levels();
        lsr_err_i = 1; #1;
        check("R6 error level", C_LINE);
        lsr_err_i = 0; #1;
        check("R5 release same cycle", C_NONE);
        rx_ready_i = 1; #1;
        check("R6 rx data level", C_RXDAT);
        rx_timeout_i = 1; #1;
        check("R3 timeout over data", C_RXTO);
        lsr_err_i = 1; #1;
        check("R2 error over timeout", C_LINE);
        lsr_err_i = 0; rx_timeout_i = 0; rx_ready_i = 0; tick();
        check("R6 levels gone", C_NONE);
    endtask

    task automatic t_tx();
        tx_space_i = 1; tick(); tx_space_i = 0;
        check("R7 tx pending", C_TX);
        ident_read();
        check("R7 ident read clears", C_NONE);
        tx_space_i = 1; tick(); tx_space_i = 0;
        tx_wr_i = 1; tick(); tx_wr_i = 0;
        check("R7 tx write clears", C_NONE);
        tx_space_i = 1; tx_wr_i = 1; tick(); tx_space_i = 0; tx_wr_i = 0;
        check("R7 set wins", C_TX);
        ident_read();
    endtask

    task automatic t_modem_gpio();
        modem_chg_i = 1; gpio_chg_i = 1; tick(); modem_chg_i = 0; gpio_chg_i = 0;
        check("R2 modem over gpio", C_MODEM);
        ident_read();
        check("R8 ident read keeps modem", C_MODEM);
        msr_rd_i = 1; tick(); msr_rd_i = 0;
        check("R8 modem read clears", C_GPIO);
        ident_read();
        check("R8 ident read keeps gpio", C_GPIO);
        gpio_rd_i = 1; tick(); gpio_rd_i = 0;
        check("R8 gpio read clears", C_NONE);
    endtask

    task automatic t_flow();
        xoff_det_i = 1; tick(); xoff_det_i = 0;
        check("R9 stop char pending", C_FLOW);
        ident_read();
        check("R9 survives ident read", C_FLOW);
        xon_det_i = 1; tick(); xon_det_i = 0;
        check("R9 resume clears", C_NONE);
        spec_det_i = 1; tick(); spec_det_i = 0;
        check("R10 special pending", C_FLOW);
        ident_read();
        check("R10 ident read clears", C_NONE);
    endtask

    task automatic t_hshk();
        cts_i = 1; tick();
        check("R11 cts rise", C_HSHK);
        ident_read();
        check("R11 ident read clears", C_NONE);
        cts_i = 0; tick(); tick();
        check("R11 falling ignored", C_NONE);
        rts_i = 1; tick();
        check("R11 rts rise", C_HSHK);
        ident_read();
        rts_i = 0; tick(); tick();
        check("R11 rts fall ignored", C_NONE);
    endtask

    task automatic t_enable();
        en_i = 7'h00;
        tx_space_i = 1; lsr_err_i = 1; tick(); tx_space_i = 0;
        check("R4 all masked", C_NONE);
        ident_read();
        lsr_err_i = 0;
        en_i = 7'b0000100; #1;
        check("R4 latched tx shown on enable", C_TX);
        en_i = 7'b1111011; #1;
        check("R4 tx masked again", C_NONE);
        en_i = 7'h7F; ident_read();
        check("R7 cleared after unmask", C_NONE);
    endtask

    task automatic t_all();
        lsr_err_i = 1; rx_timeout_i = 1; rx_ready_i = 1;
        tx_space_i = 1; modem_chg_i = 1; gpio_chg_i = 1; xoff_det_i = 1; cts_i = 1;
        tick();
        tx_space_i = 0; modem_chg_i = 0; gpio_chg_i = 0; xoff_det_i = 0;
        check("R2 rank1", C_LINE);
        lsr_err_i = 0; #1;
        check("R2 rank2 timeout", C_RXTO);
        rx_timeout_i = 0; #1;
        check("R2 rank2 data", C_RXDAT);
        rx_ready_i = 0; #1;
        check("R2 rank3", C_TX);
        ident_read();
        check("R2 rank4", C_MODEM);
        msr_rd_i = 1; tick(); msr_rd_i = 0;
        check("R2 rank5", C_GPIO);
        gpio_rd_i = 1; tick(); gpio_rd_i = 0;
        check("R2 rank6", C_FLOW);
        xon_det_i = 1; tick(); xon_det_i = 0;
        check("R2 rank7", C_HSHK);
        ident_read();
        check("R5 all clear", C_NONE);
        cts_i = 0; tick();
    endtask

    initial begin
        tick();
        t_reset();
        t_levels();
        t_tx();
        t_modem_gpio();
        t_flow();
        t_hshk();
        t_enable();
        t_all();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule